// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lets an external bus master read and write a small register file that sits beside it. It samples the open-drain SCL and SDA lines through a synchronizer clocked by the system clock. It recognises START, repeated START and STOP conditions, answers to one fixed 7-bit device address, and pulls SDA low through `sda_oe_o` when it acknowledges a byte or sends a zero bit.

Register access goes through a byte pointer. The pointer is kept from one transaction to the next and is set only by the first byte after a write address. A read always begins at the stored pointer. To read from a chosen location, the master writes the pointer byte, issues a repeated START, and then sends the read address. The register file itself is outside the block: the block presents the pointer on `reg_addr_o`, issues one-cycle write strobes, and takes read data back combinationally from `reg_rdata_i`.

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 7'b1101000, by holding SDA low through the ninth SCL clock. Bit 0 of that byte selects the direction: 0 (byte D0h) for a write, 1 (byte D1h) for a read.
- R2: When an address byte does not match, the block gives no acknowledge, never drives SDA, and issues no register write until the next START.
- R3: In a write, the first byte after the address loads its low 4 bits into the pointer; its upper bits are ignored. The byte is acknowledged and no register write occurs.
- R4: Each further write byte produces a one-cycle `reg_we_o` pulse, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte. The byte is acknowledged and the pointer then advances by one.
- R5: A read sends bytes starting at the current pointer, most significant bit first, without loading a new pointer. The pointer advances after each byte sent, and a master ACK requests the next byte.
- R6: A master NACK ends the read. SDA is released and stays released for any further SCL clocks until a START or STOP.
- R7: Reset clears the pointer to 0 and releases SDA. The pointer wraps from 0Fh to 00h and keeps its value across STOP.
- R8: A repeated START is taken as a new address phase and does not change the pointer, so a pointer write followed by a repeated-START read returns data from the written location.
- R9: A STOP at any point, including inside a byte, returns the block to idle. Bus clocks that follow without a START are ignored.
- R10: The SDA drive changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | AW | Register pointer, used as the address for both reads and writes |
| reg_wdata_o | output | 8 | Write data, valid while `reg_we_o` is high |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Read data at `reg_addr_o`, combinational |

## Verification
Pointer writes to 0Eh followed by three data bytes check the wrap. A design that did not wrap, or that advanced the pointer before storing, would leave bytes at the wrong locations. Foreign addresses and a STOP in the middle of a byte, each followed by clocks sent without a START, catch a block that keeps decoding or acknowledges bytes meant for another device. A NACK followed by an extra byte of clocks catches a transmitter that keeps driving. Plain reads after random writes expose a pointer that is not kept across STOP or repeated START. A monitor also flags any SDA drive change while SCL is high, which would show up on the bus as a false START or STOP.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NEXT,
    ST_WAIT
  } st_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  // idle bus is high, so reset the chain to ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_pipe[i] <= scl_pipe[i-1];
        sda_pipe[i] <= sda_pipe[i-1];
      end
      scl_q <= scl_pipe[STAGES-1];
      sda_q <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1;
  end

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && ptr_o == '1) |=> (ptr_o == '0)); // R7

  AST_PTR_ONLY_ON_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> $stable(ptr_o)); // R7
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         AW       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              ptr_load_o,
  output logic [AW-1:0]     ptr_val_o,
  output logic              ptr_inc_o,
  output logic              we_o,
  output logic [BYTE_W-1:0] wdata_o
);
  localparam logic [CNT_W-1:0] LastBit = CNT_W'(BYTE_W);

  st_e               state;
  byte_kind_e        kind;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              rw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      kind       <= BK_ADDR;
      bit_cnt    <= '0;
      shreg      <= '0;
      rw         <= 1'b0;
      sda_oe_o   <= 1'b0;
      ptr_load_o <= 1'b0;
      ptr_inc_o  <= 1'b0;
      we_o       <= 1'b0;
    end else begin
      ptr_load_o <= 1'b0;
      ptr_inc_o  <= 1'b0;
      we_o       <= 1'b0;
      if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        state    <= ST_RX;
        kind     <= BK_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise_i) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i && bit_cnt == LastBit) begin
              unique case (kind)
                BK_ADDR: begin
                  if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                    rw       <= shreg[0];
                    sda_oe_o <= 1'b1;
                    state    <= ST_RX_ACK;
                  end else begin
                    state <= ST_WAIT;
                  end
                end
                BK_PTR: begin
                  ptr_load_o <= 1'b1;
                  sda_oe_o   <= 1'b1;
                  state      <= ST_RX_ACK;
                end
                default: begin
                  we_o     <= 1'b1;
                  sda_oe_o <= 1'b1;
                  state    <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              bit_cnt <= '0;
              if (kind == BK_ADDR && rw) begin
                shreg    <= rdata_i;
                sda_oe_o <= ~rdata_i[BYTE_W-1];
                state    <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_RX;
                if (kind == BK_DATA) ptr_inc_o <= 1'b1;
                kind <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i) begin
              if (bit_cnt == LastBit) begin
                sda_oe_o  <= 1'b0;
                ptr_inc_o <= 1'b1;
                state     <= ST_TX_ACK;
              end else begin
                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            // master NACK (SDA high) ends the read
            if (scl_rise_i) state <= sda_s_i ? ST_WAIT : ST_TX_NEXT;
          end
          ST_TX_NEXT: begin
            if (scl_fall_i) begin
              shreg    <= rdata_i;
              sda_oe_o <= ~rdata_i[BYTE_W-1];
              bit_cnt  <= '0;
              state    <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_val_o = shreg[AW-1:0];
  assign wdata_o   = shreg;

  AST_WAIT_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT) |-> !sda_oe_o); // R2

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe_o); // R9

  AST_ACK_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RX_ACK) |-> sda_oe_o); // R1

  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o); // R4

  AST_TX_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_TX) |-> rw); // R5

  AST_START_NEW_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (state == ST_RX && kind == BK_ADDR && bit_cnt == '0)); // R8

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o) && !$past(start_i || stop_i)) |-> !$past(scl_s_i)); // R10
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         AW          = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic ptr_load, ptr_inc;
  logic [AW-1:0] ptr_val;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .rdata_i    (reg_rdata_i),
    .sda_oe_o   (sda_oe_o),
    .ptr_load_o (ptr_load),
    .ptr_val_o  (ptr_val),
    .ptr_inc_o  (ptr_inc),
    .we_o       (reg_we_o),
    .wdata_o    (reg_wdata_o)
  );

  i2c_tgt_ptr #(.AW(AW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (ptr_val),
    .inc_i      (ptr_inc),
    .ptr_o      (reg_addr_o)
  );

  AST_WE_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $stable(reg_addr_o)); // R4
endmodule

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic reg_we;
  wire  sda_line = sda_m & ~sda_oe;

  logic [7:0] mem [16];
  logic [7:0] exp_mem [16];
  logic [7:0] dbuf [8];
  logic [3:0] exp_ptr;
  int n_chk = 0, n_fail = 0, we_cnt = 0, viol = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_reg_target u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) begin mem[reg_addr] <= reg_wdata; we_cnt <= we_cnt + 1; end

  // R10 monitor: drive must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic bus_rstart();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic wb(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    end
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); ack = ~sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic rb(output logic [7:0] b, input logic mack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 0; tick(Q);
    end
    sda_m = ~mack; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q); sda_m = 1;
  endtask

  // write n bytes from dbuf starting at pointer p; hi = upper nibble of pointer byte
  task automatic do_write(input logic [3:0] p, input logic [3:0] hi, input int n);
    logic ack;
    bus_start();
    wb(8'hD0, ack); chk("R1 write addr ack", ack, 1);
    wb({hi, p}, ack); chk("R3 ptr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      wb(dbuf[i], ack); chk("R4 data ack", ack, 1);
      exp_mem[4'(p + i)] = dbuf[i];
    end
    bus_stop();
    exp_ptr = 4'(p + n);
    for (int i = 0; i < n; i++) chk("R4 stored byte", mem[4'(p + i)], exp_mem[4'(p + i)]);
  endtask

  // read n bytes; with dummy, set pointer to p first and use repeated START
  task automatic do_read(input bit dummy, input logic [3:0] p, input int n);
    logic ack;
    logic [7:0] b;
    bus_start();
    if (dummy) begin
      wb(8'hD0, ack); chk("R1 dummy addr ack", ack, 1);
      wb({4'h0, p}, ack); chk("R3 dummy ptr ack", ack, 1);
      bus_rstart();
      exp_ptr = p;
    end
    wb(8'hD1, ack); chk("R1 read addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rb(b, i < n - 1);
      chk(dummy ? "R8 read data" : "R5 read data", b, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 1'b1;
    end
    bus_stop();
  endtask

  task automatic chk_all_mem(input string req);
    for (int i = 0; i < 16; i++) chk(req, mem[i], exp_mem[i]);
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int w0;
    void'($urandom(32'h1C2D));
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'(i * 29 + 7);
      exp_mem[i] = mem[i];
    end
    exp_ptr = 0;
    tick(5);
    chk("R7 reset sda_oe", sda_oe, 0);
    chk("R7 reset we", reg_we, 0);
    chk("R7 reset ptr", reg_addr, 0);
    rst_n = 1;
    tick(5);

    // R7: plain read right after reset starts at 0
    do_read(0, 0, 2);

    // R4/R7: wrap from 0Fh to 00h, upper pointer bits ignored (R3)
    dbuf[0] = 8'hA1; dbuf[1] = 8'hB2; dbuf[2] = 8'hC3;
    do_write(4'hE, 4'hF, 3);
    chk("R7 ptr after wrap", reg_addr, 1);
    do_read(1, 4'hE, 3);

    // R3: pointer-only write stores nothing
    w0 = we_cnt;
    do_write(4'h9, 4'h0, 0);
    chk("R3 no write on ptr byte", we_cnt, w0);
    do_read(0, 0, 1); // R7 persistence: reads from 9

    // R2: foreign address, then data-like bytes
    w0 = we_cnt;
    bus_start();
    wb(8'hA0, ack); chk("R2 no ack foreign", ack, 0);
    wb(8'h03, ack); chk("R2 no ack after foreign", ack, 0);
    wb(8'h55, ack); chk("R2 no ack data", ack, 0);
    bus_stop();
    wb(8'hD1, ack); chk("R2 read addr low bit mismatch form", ack, 0);
    chk("R2 no writes", we_cnt, w0);
    chk_all_mem("R2 memory intact");
    // D1h without START was clocked above; it must be ignored (R9)
    bus_start(); wb(8'hD2, ack); chk("R2 near-miss addr", ack, 0); bus_stop();

    // R6: NACK then extra clocks, no drive
    bus_start();
    wb(8'hD1, ack); chk("R1 read ack", ack, 1);
    rb(b, 0); chk("R6 byte before nack", b, exp_mem[exp_ptr]); exp_ptr = exp_ptr + 1'b1;
    chk("R6 released after nack", sda_oe, 0);
    rb(b, 0); chk("R6 no drive after nack", b, 8'hFF);
    bus_stop();

    // R9: STOP inside a data byte, then clocks without START
    w0 = we_cnt;
    bus_start();
    wb(8'hD0, ack); chk("R1 addr ack", ack, 1);
    wb(8'h05, ack); chk("R3 ptr ack", ack, 1);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b1; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    end
    bus_stop();
    wb(8'h77, ack); chk("R9 ignored after stop", ack, 0);
    wb(8'h88, ack); chk("R9 ignored after stop 2", ack, 0);
    chk("R9 no writes", we_cnt, w0);
    exp_ptr = 5;
    do_read(0, 0, 2);

    // random mix
    for (int t = 0; t < 30; t++) begin
      int op, n;
      logic [3:0] p;
      op = $urandom_range(0, 2);
      n  = $urandom_range(1, 4);
      p  = 4'($urandom);
      if (op == 0) begin
        for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
        do_write(p, 4'($urandom), n);
      end else if (op == 1) do_read(1, p, n);
      else do_read(0, 0, n);
    end
    chk_all_mem("R4 final memory");
    chk("R10 drive only while scl low", viol, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule